// File: doc/BRIEF.md
# Sampled Switch Debouncer with Held Output

This block cleans the signal from a bouncing mechanical contact. A prescaler divides the system clock into a slow one-cycle sample strobe, nominally one every 10 ms. On each strobe the synchronized contact level moves into a short shift register. A unanimity vote then looks at the live synchronized level together with every stored sample. When all of them read high, the held output is set. When all of them read low, it is cleared. When they disagree, it keeps its value. Both the closing edge and the opening edge are filtered this way.

The stored span is the stage count times the sample period. Choose the two so that the span covers the worst bounce time of the contact. More stages lengthen the window and make a false change less likely. The contact input is asynchronous, so it first passes through a two-flop synchronizer. Every register uses the one system clock. Two single-cycle pulses mark the cycles in which the held output rises and falls. All pins are plain control or status signals, and none has a handshake.

Top module: `switch_debouncer`

## Requirements
- R1: While synchronous active-high reset is asserted, the synchronizer, the sample register and the held output all take the level given by the IDLE parameter (default 0), and both edge pulses are 0.
- R2: The sample strobe fires once every DIV system clock cycles. The first strobe falls on the DIV-th rising edge after reset is released. The held output changes only on the edge that ends a strobe cycle.
- R3: On a strobe, if the live synchronized level and all DEPTH stored samples are 1, the held output becomes 1 on that edge.
- R4: On a strobe, if the live synchronized level and all DEPTH stored samples are 0, the held output becomes 0 on that edge.
- R5: On a strobe where the DEPTH+1 voted bits are mixed, the held output keeps its value. A single opposite sample restarts the wait.
- R6: rise_o is 1 for exactly the one cycle in which level_o goes from 0 to 1. fall_o is 1 for exactly the one cycle in which level_o goes from 1 to 0. The two are never 1 together.
- R7: If the contact input stays at a level L, level_o equals L no more than (DEPTH+1)*DIV+3 cycles after the input settles.
- R8: The contact input reaches the vote through two flip-flops. A new level takes part in a vote only after it has been present for two rising edges.
- R9: A burst of toggles that lasts fewer than DEPTH*DIV cycles and returns to the starting level never changes level_o.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous reset, active high |
| contact_i | input | 1 | Raw, asynchronous switch level |
| level_o | output | 1 | Debounced held level |
| rise_o | output | 1 | One-cycle pulse when level_o goes high |
| fall_o | output | 1 | One-cycle pulse when level_o goes low |

## Verification
The properties assume that reset is applied at the start, so the registers hold defined values before the first vote. They also assume DIV is at least 2, so a strobe is never present on consecutive cycles. The contact input may change on any cycle, and the properties make no assumption about it. The stimulus changes the contact only on falling clock edges and starts with several reset cycles. It uses DIV=4 and DEPTH=3, so both short glitch bursts and settled levels fit within a run of a few thousand cycles.

// File: rtl/swdb_pkg.sv
package swdb_pkg;
  // Result of the unanimity vote over the live level and stored samples
  typedef struct packed {
    logic all_hi;
    logic all_lo;
  } vote_t;

  // Counter width for a divide ratio, never below one bit
  function automatic int cnt_width(input int ratio);
    return (ratio > 1) ? $clog2(ratio) : 1;
  endfunction
endpackage

// File: rtl/swdb_sync.sv
module swdb_sync #(
  parameter int STAGES = 2,
  parameter bit IDLE   = 1'b0
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic async_i,
  output logic sync_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) chain_q <= {STAGES{IDLE}};
    else       chain_q <= {chain_q[STAGES-2:0], async_i};
  end

  assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/swdb_tick.sv
module swdb_tick #(
  parameter int DIV = 1250000
) (
  input  logic clk_i,
  input  logic rst_i,
  output logic tick_o
);
  localparam int CW = swdb_pkg::cnt_width(DIV);
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i) begin
    if (rst_i)             cnt_q <= '0;
    else if (cnt_q == LAST) cnt_q <= '0;
    else                   cnt_q <= cnt_q + 1'b1;
  end

  assign tick_o = (cnt_q == LAST);
endmodule

// File: rtl/swdb_vote.sv
module swdb_vote #(
  parameter int DEPTH = 3,
  parameter bit IDLE  = 1'b0
) (
  input  logic               clk_i,
  input  logic               rst_i,
  input  logic               tick_i,
  input  logic               live_i,
  output logic [DEPTH:0]     taps_o,
  output swdb_pkg::vote_t    vote_o
);
  logic [DEPTH-1:0] hist_q;

  always_ff @(posedge clk_i) begin
    if (rst_i)       hist_q <= {DEPTH{IDLE}};
    else if (tick_i) hist_q <= {hist_q[DEPTH-2:0], live_i};
  end

  assign taps_o        = {hist_q, live_i};
  assign vote_o.all_hi = &taps_o;
  assign vote_o.all_lo = ~|taps_o;
endmodule

// File: rtl/swdb_hold.sv
module swdb_hold #(
  parameter bit IDLE = 1'b0
) (
  input  logic            clk_i,
  input  logic            rst_i,
  input  logic            tick_i,
  input  swdb_pkg::vote_t vote_i,
  output logic            level_o,
  output logic            rise_o,
  output logic            fall_o
);
  logic set_now, clr_now;

  assign set_now = tick_i && vote_i.all_hi && !level_o;
  assign clr_now = tick_i && vote_i.all_lo && level_o;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      level_o <= IDLE;
      rise_o  <= 1'b0;
      fall_o  <= 1'b0;
    end else begin
      rise_o <= set_now;
      fall_o <= clr_now;
      if (set_now)      level_o <= 1'b1;
      else if (clr_now) level_o <= 1'b0;
    end
  end
endmodule

// File: rtl/switch_debouncer.sv
module switch_debouncer #(
  parameter int DIV       = 1250000,
  parameter int DEPTH     = 3,
  parameter int SYNC_FFS  = 2,
  parameter bit IDLE      = 1'b0
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic contact_i,
  output logic level_o,
  output logic rise_o,
  output logic fall_o
);
  logic            live_lvl;
  logic            smp_tick;
  logic [DEPTH:0]  vote_vec;
  swdb_pkg::vote_t vote_res;

  swdb_sync #(.STAGES(SYNC_FFS), .IDLE(IDLE)) u_sync (
    .clk_i(clk_i), .rst_i(rst_i), .async_i(contact_i), .sync_o(live_lvl)
  );

  swdb_tick #(.DIV(DIV)) u_tick (
    .clk_i(clk_i), .rst_i(rst_i), .tick_o(smp_tick)
  );

  swdb_vote #(.DEPTH(DEPTH), .IDLE(IDLE)) u_vote (
    .clk_i(clk_i), .rst_i(rst_i), .tick_i(smp_tick), .live_i(live_lvl),
    .taps_o(vote_vec), .vote_o(vote_res)
  );

  swdb_hold #(.IDLE(IDLE)) u_hold (
    .clk_i(clk_i), .rst_i(rst_i), .tick_i(smp_tick), .vote_i(vote_res),
    .level_o(level_o), .rise_o(rise_o), .fall_o(fall_o)
  );
endmodule

// File: rtl/swdb_checker.sv
module swdb_checker #(
  parameter int DEPTH = 3
) (
  input logic           clk_i,
  input logic           rst_i,
  input logic           tick_i,
  input logic [DEPTH:0] vote_i,
  input logic           level_i,
  input logic           rise_i,
  input logic           fall_i
);
  a_r2_change_on_tick: assert property (@(posedge clk_i) disable iff (rst_i)
    (level_i != $past(level_i)) |-> $past(tick_i));

  a_r2_no_back_to_back: assert property (@(posedge clk_i) disable iff (rst_i)
    tick_i |=> !tick_i);

  a_r3_set_on_all_high: assert property (@(posedge clk_i) disable iff (rst_i)
    (tick_i && (&vote_i)) |=> level_i);

  a_r4_clear_on_all_low: assert property (@(posedge clk_i) disable iff (rst_i)
    (tick_i && !(|vote_i)) |=> !level_i);

  a_r5_hold_on_mixed: assert property (@(posedge clk_i) disable iff (rst_i)
    (tick_i && (|vote_i) && !(&vote_i)) |=> $stable(level_i));

  a_r6_rise_marks_edge: assert property (@(posedge clk_i) disable iff (rst_i)
    rise_i |-> (level_i && !$past(level_i)));

  a_r6_fall_marks_edge: assert property (@(posedge clk_i) disable iff (rst_i)
    fall_i |-> (!level_i && $past(level_i)));

  a_r6_exclusive: assert property (@(posedge clk_i) disable iff (rst_i)
    $onehot0({rise_i, fall_i}));
endmodule

bind switch_debouncer swdb_checker #(.DEPTH(DEPTH)) u_chk (
  .clk_i(clk_i), .rst_i(rst_i), .tick_i(smp_tick), .vote_i(vote_vec),
  .level_i(level_o), .rise_i(rise_o), .fall_i(fall_o)
);

// File: tb/test_switch_debouncer.sv
module test_switch_debouncer;
  localparam int DIV   = 4;
  localparam int DEPTH = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic contact = 1'b0;
  logic level, rise, fall;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;
  int rises_seen = 0;
  int falls_seen = 0;

  always #4 clk = ~clk;

  switch_debouncer #(.DIV(DIV), .DEPTH(DEPTH)) i_switch_debouncer (
    .clk_i(clk), .rst_i(rst), .contact_i(contact),
    .level_o(level), .rise_o(rise), .fall_o(fall)
  );

  // Behavioural reference, advanced on each rising edge
  int m_cnt;
  bit m_s1, m_s2, m_q, m_rise, m_fall;
  bit samp[$];

  always @(posedge clk) begin
    if (rst) begin
      m_cnt = 0; m_s1 = 0; m_s2 = 0; m_q = 0; m_rise = 0; m_fall = 0;
      samp = {};
      for (int i = 0; i < DEPTH; i++) samp.push_back(1'b0);
    end else begin
      bit tk, hi, lo, nq, nr, nf;
      tk = (m_cnt == DIV - 1);
      nq = m_q; nr = 0; nf = 0;
      if (tk) begin
        hi = m_s2; lo = !m_s2;
        foreach (samp[i]) begin hi &= samp[i]; lo &= !samp[i]; end
        if (hi && !m_q) begin nq = 1; nr = 1; end
        else if (lo && m_q) begin nq = 0; nf = 1; end
        samp.push_front(m_s2);
        void'(samp.pop_back());
      end
      m_cnt = tk ? 0 : m_cnt + 1;
      m_s2 = m_s1; m_s1 = contact;
      m_q = nq; m_rise = nr; m_fall = nf;
    end
  end

  task automatic check(input bit cond, input string req, input int act, input int exp);
    checks++;
    if (!cond) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Every-cycle comparison against the reference
  always @(negedge clk) begin
    if (!rst && !done) begin
      check(level == m_q, "R2 R3 R4 R5 R8 level vs model", level, m_q);
      check(rise == m_rise, "R6 rise vs model", rise, m_rise);
      check(fall == m_fall, "R6 fall vs model", fall, m_fall);
      if (rise) rises_seen++;
      if (fall) falls_seen++;
    end
  end

  task automatic settle(input bit lvl);
    contact = lvl;
    repeat ((DEPTH + 1) * DIV + 3) @(negedge clk);
    check(level == lvl, "R7 settled level followed", level, lvl);
  endtask

  task automatic burst(input bit base, input int len);
    for (int i = 0; i < len - 1; i++) begin
      contact = 1'($urandom_range(0, 1));
      @(negedge clk);
      check(level == base, "R9 level held during burst", level, base);
    end
    contact = base;
    repeat (DEPTH * DIV + 4) @(negedge clk);
    check(level == base, "R9 level held after burst", level, base);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(level == 1'b0, "R1 reset level", level, 0);
    check(rise == 1'b0 && fall == 1'b0, "R1 reset pulses", {rise, fall}, 0);
    rst = 1'b0;

    // R8: a one-cycle glitch never accepted
    contact = 1'b1; @(negedge clk); contact = 1'b0;
    repeat (20) @(negedge clk);
    check(level == 1'b0, "R8 R5 single glitch ignored", level, 0);

    settle(1'b1);
    check(rises_seen == 1, "R3 R6 one rise pulse", rises_seen, 1);
    for (int b = 0; b < 8; b++) burst(1'b1, DEPTH * DIV - 2);
    settle(1'b0);
    check(falls_seen == 1, "R4 R6 one fall pulse", falls_seen, 1);
    for (int b = 0; b < 8; b++) burst(1'b0, DEPTH * DIV - 2);

    // R5: one opposite sample restarts the wait
    contact = 1'b1;
    repeat (2 * DIV) @(negedge clk);
    contact = 1'b0; repeat (DIV) @(negedge clk); contact = 1'b1;
    repeat (2 * DIV) @(negedge clk);
    check(level == 1'b0, "R5 wait restarted by low sample", level, 0);
    settle(1'b1);

    // R2: output edges follow the strobe period under slow random levels
    for (int k = 0; k < 40; k++) begin
      contact = 1'($urandom_range(0, 1));
      repeat ($urandom_range(1, 30)) @(negedge clk);
    end
    settle(1'b0);
    check(rises_seen == falls_seen, "R6 rise and fall balance", rises_seen, falls_seen);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule